// File: doc/BRIEF.md
# Operand Specifier Decoder

This block decodes one variable-length operand specifier from an instruction byte stream. Bytes arrive one per cycle over a valid/ready handshake. The first byte is a descriptor. Its upper nibble selects the addressing mode and its lower nibble holds a register number. The decoder works out how many more bytes the specifier needs and collects them. These bytes can be an immediate, a displacement or an absolute address. The decoder then presents one decoded record.

A descriptor whose mode nibble is 14, with a register nibble below 15, is a type-override prefix. Its low nibble is the overriding operand type, and a second descriptor follows that chooses the real mode. Two side inputs say whether the operand is written, and whether the instruction uses the operand's address. Literal and immediate forms are flagged as errors under either condition. The decoder does not form addresses, touch memory, decode opcodes or execute anything.

Top module: `opspec_decoder`

## Requirements
- R1: While reset is held, and after it is released, `byte_ready_o` is 1, `done_o` is 0, and `mode_o`, `value_o`, `len_o` and `err_o` are 0.
- R2: A descriptor with mode nibble 0–3 reports mode code 0 (positive literal). A descriptor with mode nibble 15 reports mode code 1 (negative literal). Both take 1 byte and accept any register nibble. Code 0 gives the descriptor zero-extended (0–63) as its value, and code 1 gives it sign-extended.
- R3: With register nibble 15, mode nibbles 4, 5 and 6 are word, halfword and byte immediates. They report codes 8, 7 and 6, take 5, 3 and 2 bytes in total, and give the raw value zero-filled. `size_o` is 3, 2 and 1 for them. Mode nibble 7 is absolute (code 9) and mode nibble 14 is absolute deferred (code 10), both 5 bytes.
- R4: With register nibble below 15, mode nibbles 4, 5, 6 and 7 report codes 2 (register), 3 (register deferred), 4 (frame-pointer short offset) and 5 (argument-pointer short offset). Each takes 1 byte. Both short offsets report the register nibble as their value.
- R5: Mode nibbles 8/9 report codes 15/16 (word displacement, plain and deferred) and take 5 bytes. Nibbles 10/11 report codes 13/14 (halfword) and take 3 bytes. Nibbles 12/13 report codes 11/12 (byte) and take 2 bytes. Byte and halfword displacements are sign-extended to 32 bits.
- R6: Multi-byte fields are assembled least-significant byte first. For example, 0xFF then 0x01 gives 0x01FF.
- R7: Register number 11 raises `err_o` with register deferred and with every displacement mode. The remaining bytes of the specifier are still consumed, and the next specifier decodes normally.
- R8: Literal and immediate modes raise `err_o` when `is_dest_i` or `needs_ea_i` is 1. Both inputs are sampled with the descriptor that selects the mode. Other modes are not flagged by these inputs.
- R9: A prefix byte (mode nibble 14, register nibble below 15) sets `etype_vld_o`, reports its low nibble on `etype_o`, and adds 1 to `len_o`. The mode, register and value come from the following descriptor.
- R10: A prefix changes neither the byte count nor the value of a literal or immediate.
- R11: A prefix followed by another prefix reports mode code 17 with `err_o` set and `len_o` 2. It ends the specifier.
- R12: `done_o` is a one-cycle pulse. It is registered on the cycle after the edge that accepts the last byte. The record outputs change only on that edge and then hold.
- R13: A byte is taken only when `byte_valid_i` and `byte_ready_o` are both 1. Idle cycles between bytes do not change the result. `byte_ready_o` is 0 during the `done_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_i | input | 8 | Stream byte |
| byte_ready_o | output | 1 | Decoder can take a byte |
| is_dest_i | input | 1 | Operand is a destination |
| needs_ea_i | input | 1 | Instruction uses the operand address |
| done_o | output | 1 | Record valid pulse |
| mode_o | output | 5 | Decoded mode code |
| reg_o | output | 4 | Register nibble of the mode-selecting descriptor |
| etype_o | output | 4 | Overriding type from the prefix |
| etype_vld_o | output | 1 | A prefix was present |
| value_o | output | 32 | Embedded value |
| len_o | output | 3 | Total specifier length in bytes |
| size_o | output | 2 | Embedded field size code: 0 none, 1 byte, 2 half, 3 word |
| err_o | output | 1 | Illegal specifier |

## Verification
Each record is due exactly one cycle after the clock edge that accepts the final byte of a specifier. `done_o` rises on that same edge, and the record then holds until the next specifier finishes. The bench drives every byte at a falling edge and lets the next rising edge accept it. It samples the whole record at the falling edge that follows the last acceptance. When it inserts idle cycles, it checks at each of them that no early `done_o` appears. One scenario also samples one cycle later, to confirm that the pulse has dropped while the record stays unchanged.

// File: rtl/opspec_pkg.sv
package opspec_pkg;
  localparam int MODE_W = 5;
  localparam int NB_W   = 3;

  typedef enum logic [MODE_W-1:0] {
    AM_POS_LIT   = 5'd0,
    AM_NEG_LIT   = 5'd1,
    AM_REG       = 5'd2,
    AM_REG_DEF   = 5'd3,
    AM_FP_SHORT  = 5'd4,
    AM_AP_SHORT  = 5'd5,
    AM_IMM_B     = 5'd6,
    AM_IMM_H     = 5'd7,
    AM_IMM_W     = 5'd8,
    AM_ABS       = 5'd9,
    AM_ABS_DEF   = 5'd10,
    AM_DISP_B    = 5'd11,
    AM_DISP_B_DF = 5'd12,
    AM_DISP_H    = 5'd13,
    AM_DISP_H_DF = 5'd14,
    AM_DISP_W    = 5'd15,
    AM_DISP_W_DF = 5'd16,
    AM_XPFX      = 5'd17
  } am_e;

  typedef struct packed {
    am_e             mode;
    logic [NB_W-1:0] nbytes;   // trailing bytes after descriptor
    logic            lit_imm;
    logic            bad_reg;
    logic            prefix;
  } cls_t;
endpackage

// File: rtl/opspec_classify.sv
module opspec_classify
  import opspec_pkg::*;
#(
  parameter logic [3:0] BAD_REG = 4'd11
) (
  input  logic [7:0] desc_i,
  output cls_t       cls_o
);
  logic [3:0] m, r;
  logic       r15, r_bad;

  assign m     = desc_i[7:4];
  assign r     = desc_i[3:0];
  assign r15   = (r == 4'hF);
  assign r_bad = (r == BAD_REG);

  always_comb begin
    cls_o.mode    = AM_POS_LIT;
    cls_o.nbytes  = 3'd0;
    cls_o.lit_imm = 1'b0;
    cls_o.bad_reg = 1'b0;
    cls_o.prefix  = 1'b0;
    unique case (m)
      4'd0, 4'd1, 4'd2, 4'd3: begin
        cls_o.mode = AM_POS_LIT; cls_o.lit_imm = 1'b1;
      end
      4'd4: if (r15) begin
        cls_o.mode = AM_IMM_W; cls_o.nbytes = 3'd4; cls_o.lit_imm = 1'b1;
      end else cls_o.mode = AM_REG;
      4'd5: if (r15) begin
        cls_o.mode = AM_IMM_H; cls_o.nbytes = 3'd2; cls_o.lit_imm = 1'b1;
      end else begin
        cls_o.mode = AM_REG_DEF; cls_o.bad_reg = r_bad;
      end
      4'd6: if (r15) begin
        cls_o.mode = AM_IMM_B; cls_o.nbytes = 3'd1; cls_o.lit_imm = 1'b1;
      end else cls_o.mode = AM_FP_SHORT;
      4'd7: if (r15) begin
        cls_o.mode = AM_ABS; cls_o.nbytes = 3'd4;
      end else cls_o.mode = AM_AP_SHORT;
      4'd8: begin
        cls_o.mode = AM_DISP_W; cls_o.nbytes = 3'd4; cls_o.bad_reg = r_bad;
      end
      4'd9: begin
        cls_o.mode = AM_DISP_W_DF; cls_o.nbytes = 3'd4; cls_o.bad_reg = r_bad;
      end
      4'd10: begin
        cls_o.mode = AM_DISP_H; cls_o.nbytes = 3'd2; cls_o.bad_reg = r_bad;
      end
      4'd11: begin
        cls_o.mode = AM_DISP_H_DF; cls_o.nbytes = 3'd2; cls_o.bad_reg = r_bad;
      end
      4'd12: begin
        cls_o.mode = AM_DISP_B; cls_o.nbytes = 3'd1; cls_o.bad_reg = r_bad;
      end
      4'd13: begin
        cls_o.mode = AM_DISP_B_DF; cls_o.nbytes = 3'd1; cls_o.bad_reg = r_bad;
      end
      4'd14: if (r15) begin
        cls_o.mode = AM_ABS_DEF; cls_o.nbytes = 3'd4;
      end else begin
        cls_o.mode = AM_XPFX; cls_o.prefix = 1'b1;
      end
      default: begin
        cls_o.mode = AM_NEG_LIT; cls_o.lit_imm = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/opspec_collect.sv
module opspec_collect #(
  parameter int EMB_W = 32,
  parameter int IDX_W = $clog2(EMB_W / 8)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       byte_i,
  output logic [EMB_W-1:0] acc_nxt_o
);
  localparam int NLANE = EMB_W / 8;

  logic [EMB_W-1:0] acc_q;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_comb begin
      if (clr_i)
        acc_nxt_o[g*8 +: 8] = 8'h00;
      else if (wr_i && idx_i == IDX_W'(g))
        acc_nxt_o[g*8 +: 8] = byte_i;
      else
        acc_nxt_o[g*8 +: 8] = acc_q[g*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_nxt_o;
  end
endmodule

// File: rtl/opspec_decoder.sv
module opspec_decoder
  import opspec_pkg::*;
#(
  parameter int         EMB_W   = 32,
  parameter logic [3:0] BAD_REG = 4'd11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  output logic             byte_ready_o,
  input  logic             is_dest_i,
  input  logic             needs_ea_i,
  output logic             done_o,
  output logic [4:0]       mode_o,
  output logic [3:0]       reg_o,
  output logic [3:0]       etype_o,
  output logic             etype_vld_o,
  output logic [EMB_W-1:0] value_o,
  output logic [2:0]       len_o,
  output logic [1:0]       size_o,
  output logic             err_o
);
  localparam int IDX_W = $clog2(EMB_W / 8);

  typedef enum logic [1:0] {ST_DESC, ST_DATA, ST_DONE} st_e;

  st_e             st_q;
  logic            pfx_q, err_q;
  logic [3:0]      etype_q;
  am_e             mode_q;
  logic [7:0]      desc_q;
  logic [NB_W-1:0] nb_q, rem_q;
  logic [IDX_W-1:0] idx_q;

  cls_t             cls;
  logic [EMB_W-1:0] acc_nxt;

  logic accept, desc_acc, data_acc, take_pfx, desc_final, nested;
  logic last_data, finish, desc_err;
  logic [NB_W-1:0] eff_nb;

  am_e             f_mode;
  logic [7:0]      f_desc;
  logic            f_err;
  logic [NB_W-1:0] f_nb;

  opspec_classify #(.BAD_REG(BAD_REG)) u_cls (
    .desc_i (byte_i),
    .cls_o  (cls)
  );

  opspec_collect #(.EMB_W(EMB_W), .IDX_W(IDX_W)) u_col (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (desc_acc),
    .wr_i      (data_acc),
    .idx_i     (idx_q),
    .byte_i    (byte_i),
    .acc_nxt_o (acc_nxt)
  );

  assign byte_ready_o = (st_q != ST_DONE);
  assign done_o       = (st_q == ST_DONE);
  assign accept       = byte_valid_i & byte_ready_o;
  assign desc_acc     = accept & (st_q == ST_DESC);
  assign data_acc     = accept & (st_q == ST_DATA);
  assign take_pfx     = desc_acc & cls.prefix & ~pfx_q;
  assign desc_final   = desc_acc & ~take_pfx;
  assign nested       = pfx_q & cls.prefix;
  assign eff_nb       = nested ? '0 : cls.nbytes;
  assign desc_err     = nested | cls.bad_reg |
                        (cls.lit_imm & (is_dest_i | needs_ea_i));
  assign last_data    = data_acc & (rem_q == 3'd1);
  assign finish       = (desc_final & (eff_nb == '0)) | last_data;

  assign f_mode = (st_q == ST_DATA) ? mode_q : cls.mode;
  assign f_desc = (st_q == ST_DATA) ? desc_q : byte_i;
  assign f_err  = (st_q == ST_DATA) ? err_q  : desc_err;
  assign f_nb   = (st_q == ST_DATA) ? nb_q   : eff_nb;

  function automatic logic [EMB_W-1:0] fin_value(am_e m, logic [7:0] d,
                                                 logic [EMB_W-1:0] a);
    case (m)
      AM_POS_LIT:   fin_value = {{(EMB_W-8){1'b0}}, d};
      AM_NEG_LIT:   fin_value = {{(EMB_W-8){d[7]}}, d};
      AM_FP_SHORT,
      AM_AP_SHORT:  fin_value = {{(EMB_W-4){1'b0}}, d[3:0]};
      AM_REG, AM_REG_DEF, AM_XPFX: fin_value = '0;
      AM_DISP_B,
      AM_DISP_B_DF: fin_value = {{(EMB_W-8){a[7]}}, a[7:0]};
      AM_DISP_H,
      AM_DISP_H_DF: fin_value = {{(EMB_W-16){a[15]}}, a[15:0]};
      default:      fin_value = a;
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_DESC;
      pfx_q   <= 1'b0;
      etype_q <= '0;
      err_q   <= 1'b0;
      mode_q  <= AM_POS_LIT;
      desc_q  <= '0;
      nb_q    <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (st_q)
        ST_DESC: if (take_pfx) begin
          pfx_q   <= 1'b1;
          etype_q <= byte_i[3:0];
        end else if (desc_final) begin
          if (eff_nb == '0) st_q <= ST_DONE;
          else begin
            st_q   <= ST_DATA;
            mode_q <= cls.mode;
            desc_q <= byte_i;
            err_q  <= desc_err;
            nb_q   <= eff_nb;
            rem_q  <= eff_nb;
            idx_q  <= '0;
          end
        end
        ST_DATA: if (data_acc) begin
          rem_q <= rem_q - 3'd1;
          idx_q <= idx_q + IDX_W'(1);
          if (last_data) st_q <= ST_DONE;
        end
        default: begin
          st_q  <= ST_DESC;
          pfx_q <= 1'b0;
        end
      endcase
    end
  end

  // record registers, written only when a specifier completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o      <= '0;
      reg_o       <= '0;
      etype_o     <= '0;
      etype_vld_o <= 1'b0;
      value_o     <= '0;
      len_o       <= '0;
      size_o      <= '0;
      err_o       <= 1'b0;
    end else if (finish) begin
      mode_o      <= f_mode;
      reg_o       <= f_desc[3:0];
      etype_o     <= pfx_q ? etype_q : 4'd0;
      etype_vld_o <= pfx_q;
      value_o     <= fin_value(f_mode, f_desc, acc_nxt);
      len_o       <= 3'd1 + {2'b00, pfx_q} + f_nb;
      size_o      <= {f_nb[2] | f_nb[1], f_nb[2] | f_nb[0]};
      err_o       <= f_err;
    end
  end
endmodule

// File: rtl/opspec_decoder_chk.sv
module opspec_decoder_chk #(
  parameter int EMB_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             byte_ready_o,
  input logic             done_o,
  input logic [4:0]       mode_o,
  input logic [3:0]       reg_o,
  input logic             etype_vld_o,
  input logic [EMB_W-1:0] value_o,
  input logic [2:0]       len_o,
  input logic             err_o
);
  a_r12_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r12_value_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(value_o) |-> done_o);

  a_r12_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> done_o);

  a_r13_stall_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !byte_ready_o);

  a_r2_pos_lit_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_o == 5'd0) |->
      (value_o < 64 && len_o == 3'd1 + {2'b00, etype_vld_o}));

  a_r2_neg_lit_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_o == 5'd1) |-> (&value_o[EMB_W-1:4]));

  a_r5_byte_disp_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (mode_o == 5'd11 || mode_o == 5'd12)) |->
      (value_o[EMB_W-1:8] == {(EMB_W-8){value_o[7]}}));

  a_r7_bad_reg_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && reg_o == 4'd11 &&
     (mode_o == 5'd3 || (mode_o >= 5'd11 && mode_o <= 5'd16))) |-> err_o);
endmodule

bind opspec_decoder opspec_decoder_chk #(.EMB_W(EMB_W)) u_chk (.*);

// File: tb/opspec_decoder_test.sv
module opspec_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  data = 8'h00;
  logic        is_dest = 1'b0;
  logic        needs_ea = 1'b0;
  logic        ready, done, evld, err;
  logic [4:0]  mode;
  logic [3:0]  rg, etype;
  logic [31:0] value;
  logic [2:0]  len;
  logic [1:0]  size;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opspec_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(valid), .byte_i(data),
    .byte_ready_o(ready), .is_dest_i(is_dest), .needs_ea_i(needs_ea),
    .done_o(done), .mode_o(mode), .reg_o(rg), .etype_o(etype),
    .etype_vld_o(evld), .value_o(value), .len_o(len), .size_o(size),
    .err_o(err)
  );

  task automatic check(input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // bytes in bs, lowest byte first; gap idle cycles between bytes
  task automatic feed(input logic [47:0] bs, input int n, input logic dst,
                      input logic ea, input int gap);
    is_dest  = dst;
    needs_ea = ea;
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        for (int k = 0; k < gap; k++) begin
          @(negedge clk);
          valid = 1'b0;
          check("R13 no early done during idle", {31'b0, done}, 32'd0);
        end
      end
      @(negedge clk);
      valid = 1'b1;
      data  = bs[8*i +: 8];
      @(posedge clk);
    end
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic expect_rec(input string tag, input logic [4:0] m,
                            input logic [3:0] r, input logic [31:0] v,
                            input logic [2:0] l, input logic [1:0] s,
                            input logic e, input logic ev,
                            input logic [3:0] et);
    check({tag, " R12 done"}, {31'b0, done}, 32'd1);
    check({tag, " mode"},  {27'b0, m == mode ? m : mode}, {27'b0, m});
    check({tag, " reg"},   {28'b0, rg}, {28'b0, r});
    check({tag, " value"}, value, v);
    check({tag, " len"},   {29'b0, len}, {29'b0, l});
    check({tag, " size"},  {30'b0, size}, {30'b0, s});
    check({tag, " err"},   {31'b0, err}, {31'b0, e});
    check({tag, " etype_vld"}, {31'b0, evld}, {31'b0, ev});
    check({tag, " etype"}, {28'b0, etype}, {28'b0, et});
  endtask

  task automatic t_reset();
    #1;
    check("R1 ready in reset", {31'b0, ready}, 32'd1);
    check("R1 done in reset",  {31'b0, done}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {31'b0, ready}, 32'd1);
    check("R1 done after reset",  {31'b0, done}, 32'd0);
    check("R1 value after reset", value, 32'd0);
    check("R1 mode after reset",  {27'b0, mode}, 32'd0);
    check("R1 len after reset",   {29'b0, len}, 32'd0);
    check("R1 err after reset",   {31'b0, err}, 32'd0);
  endtask

  task automatic t_literals();
    feed(48'h25, 1, 0, 0, 0);
    expect_rec("R2 pos lit", 5'd0, 4'd5, 32'h25, 3'd1, 2'd0, 0, 0, 4'd0);
    feed(48'hF3, 1, 0, 0, 0);
    expect_rec("R2 neg lit", 5'd1, 4'd3, 32'hFFFFFFF3, 3'd1, 2'd0, 0, 0, 4'd0);
    feed(48'h3F, 1, 0, 0, 0);
    expect_rec("R2 pos lit reg15", 5'd0, 4'hF, 32'h3F, 3'd1, 2'd0, 0, 0, 4'd0);
  endtask

  task automatic t_immediates();
    feed(48'h12_34_56_78_4F, 5, 0, 0, 0);
    expect_rec("R3 imm word", 5'd8, 4'hF, 32'h12345678, 3'd5, 2'd3, 0, 0, 4'd0);
    feed(48'h01_FF_5F, 3, 0, 0, 0);
    expect_rec("R3 R6 imm half", 5'd7, 4'hF, 32'h000001FF, 3'd3, 2'd2, 0, 0, 4'd0);
    feed(48'h80_6F, 2, 0, 0, 0);
    expect_rec("R3 imm byte raw", 5'd6, 4'hF, 32'h00000080, 3'd2, 2'd1, 0, 0, 4'd0);
    feed(48'h00_00_10_00_7F, 5, 0, 0, 0);
    expect_rec("R3 absolute", 5'd9, 4'hF, 32'h00001000, 3'd5, 2'd3, 0, 0, 4'd0);
    feed(48'h01_02_03_04_EF, 5, 0, 0, 0);
    expect_rec("R3 abs deferred", 5'd10, 4'hF, 32'h01020304, 3'd5, 2'd3, 0, 0, 4'd0);
  endtask

  task automatic t_registers();
    feed(48'h43, 1, 0, 0, 0);
    expect_rec("R4 register", 5'd2, 4'd3, 32'd0, 3'd1, 2'd0, 0, 0, 4'd0);
    feed(48'h52, 1, 0, 0, 0);
    expect_rec("R4 reg deferred", 5'd3, 4'd2, 32'd0, 3'd1, 2'd0, 0, 0, 4'd0);
    feed(48'h6A, 1, 0, 0, 0);
    expect_rec("R4 fp short", 5'd4, 4'hA, 32'd10, 3'd1, 2'd0, 0, 0, 4'd0);
    feed(48'h7E, 1, 0, 0, 0);
    expect_rec("R4 ap short", 5'd5, 4'hE, 32'd14, 3'd1, 2'd0, 0, 0, 4'd0);
  endtask

  task automatic t_displacements();
    feed(48'h06_C1, 2, 0, 0, 0);
    expect_rec("R5 byte disp", 5'd11, 4'd1, 32'd6, 3'd2, 2'd1, 0, 0, 4'd0);
    feed(48'hFE_D2, 2, 0, 0, 0);
    expect_rec("R5 byte disp def neg", 5'd12, 4'd2, 32'hFFFFFFFE, 3'd2, 2'd1, 0, 0, 4'd0);
    feed(48'h80_00_A3, 3, 0, 0, 0);
    expect_rec("R5 R6 half disp neg", 5'd13, 4'd3, 32'hFFFF8000, 3'd3, 2'd2, 0, 0, 4'd0);
    feed(48'h11_22_33_44_84, 5, 0, 0, 0);
    expect_rec("R5 R6 word disp", 5'd15, 4'd4, 32'h11223344, 3'd5, 2'd3, 0, 0, 4'd0);
    feed(48'h7F_FF_FF_FF_9F, 5, 0, 0, 0);
    expect_rec("R5 word disp def r15", 5'd16, 4'hF, 32'h7FFFFFFF, 3'd5, 2'd3, 0, 0, 4'd0);
  endtask

  task automatic t_bad_reg();
    feed(48'h5B, 1, 0, 0, 0);
    expect_rec("R7 reg def r11", 5'd3, 4'd11, 32'd0, 3'd1, 2'd0, 1, 0, 4'd0);
    feed(48'h12_34_BB, 3, 0, 0, 0);
    expect_rec("R7 half disp def r11", 5'd14, 4'd11, 32'h00001234, 3'd3, 2'd2, 1, 0, 4'd0);
    feed(48'h40, 1, 0, 0, 0);
    expect_rec("R7 next specifier clean", 5'd2, 4'd0, 32'd0, 3'd1, 2'd0, 0, 0, 4'd0);
  endtask

  task automatic t_dest_ea();
    feed(48'h05, 1, 1, 0, 0);
    expect_rec("R8 literal as dest", 5'd0, 4'd5, 32'd5, 3'd1, 2'd0, 1, 0, 4'd0);
    feed(48'h11_6F, 2, 0, 1, 0);
    expect_rec("R8 imm with ea", 5'd6, 4'hF, 32'h11, 3'd2, 2'd1, 1, 0, 4'd0);
    feed(48'h40, 1, 1, 1, 0);
    expect_rec("R8 register as dest", 5'd2, 4'd0, 32'd0, 3'd1, 2'd0, 0, 0, 4'd0);
  endtask

  task automatic t_prefix();
    feed(48'h12_34_56_78_4F_E2, 6, 0, 0, 0);
    expect_rec("R9 R10 prefix imm word", 5'd8, 4'hF, 32'h12345678, 3'd6, 2'd3, 0, 1, 4'd2);
    feed(48'hF9_E7, 2, 0, 0, 0);
    expect_rec("R10 prefix neg lit", 5'd1, 4'd9, 32'hFFFFFFF9, 3'd2, 2'd0, 0, 1, 4'd7);
    feed(48'h06_C1_E4, 3, 0, 0, 0);
    expect_rec("R9 prefix byte disp", 5'd11, 4'd1, 32'd6, 3'd3, 2'd1, 0, 1, 4'd4);
    feed(48'hE3_E1, 2, 0, 0, 0);
    expect_rec("R11 nested prefix", 5'd17, 4'd3, 32'd0, 3'd2, 2'd0, 1, 1, 4'd1);
  endtask

  task automatic t_stall_pulse();
    feed(48'h01_FF_5F, 3, 0, 0, 3);
    expect_rec("R13 R6 stalled imm half", 5'd7, 4'hF, 32'h000001FF, 3'd3, 2'd2, 0, 0, 4'd0);
    check("R13 ready low in done", {31'b0, ready}, 32'd0);
    @(negedge clk);
    check("R12 done drops", {31'b0, done}, 32'd0);
    check("R12 value held", value, 32'h000001FF);
    check("R13 ready back", {31'b0, ready}, 32'd1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_literals();
    t_immediates();
    t_registers();
    t_displacements();
    t_bad_reg();
    t_dest_ea();
    t_prefix();
    t_stall_pulse();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule